// File: doc/BRIEF.md
# Dual-Framing BPSK Subcarrier Frame Receiver

The receiver takes signed I/Q correlator samples of a BPSK-modulated subcarrier, two samples per elementary time unit (etu). It first learns a phase reference from a run of unmodulated subcarrier. It then makes a soft decision on every bit by correlating each sample against that reference, and assembles 10-bit characters into bytes.

Two framings are accepted through one path. In the reduced framing, data begins straight after the reference run. In the full framing, a long low start-of-frame (SOF) comes first. The first phase flip after training always starts bit collection. An all-zero character is read as the end of frame (EOF) once a byte has been taken. Before any byte has been taken, the same character is read as the SOF low phase, which is still running.

Downstream logic sees a byte strobe with data, an EOF pulse, a sync-lost pulse and an active flag. Samples are consumed only on cycles where the valid input is high.

Top module: `bpsk_frame_rx`

## Requirements
- R1: After reset, byte_valid_o, eof_o, sync_lost_o and active_o are low and the receiver is idle. byte_o reads 0.
- R2: In the idle state, a sample with |I|+|Q| greater than THRESH (default 24) starts training. A sample at or below THRESH does not start training. During training, a sample at or below THRESH pulses sync_lost_o and returns to idle.
- R3: A training sample matches the reference when its sign agrees with the reference sum on the dominant axis. The dominant axis is I when |sumI| > |sumQ|, and Q otherwise. A sample that disagrees on the dominant axis counts as a phase flip even if the other axis agrees.
- R4: The first training sample counts as matching sample 1. Only the first 10 matching samples are added into the reference. A flip seen when fewer than 10 matching samples exist pulses sync_lost_o. A flip seen at 10 or more becomes the first half of the first bit, and active_o goes high.
- R5: Each bit is the sign of the sum, over the two samples of one etu, of the dot product with the reference. A positive sum is logic 1. A weak opposite first half does not change a bit whose second half is strong.
- R6: A character is a start 0, then 8 data bits LSB first, then a stop 1. Such a character raises byte_valid_o with its data on byte_o in the cycle after the stop bit's second sample. Character search then resumes: the first sample with a negative dot product starts the next character, and logic-1 stuff bits between characters are ignored.
- R7: An all-zero character that follows at least one byte pulses eof_o, without sync_lost_o, and returns to idle.
- R8: An all-zero character that comes before any byte is treated as SOF low. The sample counter is preset to 20 and rises by 1 on each later sample. A positive sample is accepted as the SOF rising edge when the count is at least 18, which sets active_o. A low sample that takes the count above 24 pulses sync_lost_o. Up to 4 further low samples are therefore tolerated.
- R9: Any other completed character pulses sync_lost_o and returns to idle. This covers a stop bit of 0 with non-zero content and a start bit of 1.
- R10: active_o is high exactly while the receiver is waiting for a start bit or collecting bits. It is low while waiting for the SOF rising edge.
- R11: Cycles with smp_valid_i low change no state and produce no pulse.
- R12: byte_valid_o, eof_o and sync_lost_o are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_i_i | input | SMP_W | Signed in-phase correlator sample |
| smp_q_i | input | SMP_W | Signed quadrature correlator sample |
| byte_valid_o | output | 1 | Byte strobe |
| byte_o | output | 8 | Last received byte |
| eof_o | output | 1 | End-of-frame pulse |
| sync_lost_o | output | 1 | Synchronisation lost pulse |
| active_o | output | 1 | Frame in progress past SOF detection |

## Verification
Some rules hold in every cycle, and the assertions check those. The event outputs stay exclusive one-cycle pulses. An EOF pulse never occurs unless a byte came first. A byte strobe leaves the receiver active, and sync loss leaves it inactive. The SOF counter never sits above its limit. The reference stops moving once training saturates, the bit counter stays in range, and invalid cycles freeze the state. The value-level behaviours can only be shown by the bench scenarios:
- which axis decides a flip;
- the 9-versus-10 training boundary;
- soft combining of a weak half;
- LSB-first byte assembly across stuff bits;
- the all-zero character read as SOF or as EOF;
- the edges of the SOF low window.

// File: rtl/bpsk_rx_pkg.sv
package bpsk_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRAIN,
    ST_SOF_RISE,
    ST_WAIT_START,
    ST_DATA
  } rx_state_e;

  typedef enum logic [1:0] {
    CH_SOF_EOF,
    CH_BYTE,
    CH_BAD
  } char_kind_e;
endpackage

// File: rtl/bpsk_ref_acc.sv
module bpsk_ref_acc #(
  parameter int SMP_W     = 8,
  parameter int ACC_W     = 13,
  parameter int TRAIN_LEN = 10,
  parameter int THRESH    = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    upd_i,
  input  logic signed [SMP_W-1:0] smp_i_i,
  input  logic signed [SMP_W-1:0] smp_q_i,
  output logic signed [ACC_W-1:0] ref_i_o,
  output logic signed [ACC_W-1:0] ref_q_o,
  output logic                    amp_ok_o,
  output logic                    match_o,
  output logic                    trained_o
);
  localparam int CNT_W = $clog2(TRAIN_LEN + 1);
  localparam int AMP_W = SMP_W + 2;

  logic signed [SMP_W:0] ext_i, ext_q;
  logic [SMP_W:0]        abs_i, abs_q;
  logic [AMP_W-1:0]      amp;
  logic signed [ACC_W:0] rext_i, rext_q;
  logic [ACC_W:0]        rabs_i, rabs_q;
  logic                  i_dom, s_pos_i, s_neg_i, s_pos_q, s_neg_q;
  logic                  r_pos_i, r_neg_i, r_pos_q, r_neg_q;
  logic [CNT_W-1:0]      cnt_q;

  always_comb begin
    ext_i  = (SMP_W+1)'(smp_i_i);
    ext_q  = (SMP_W+1)'(smp_q_i);
    abs_i  = ext_i[SMP_W] ? -ext_i : ext_i;
    abs_q  = ext_q[SMP_W] ? -ext_q : ext_q;
    amp    = {1'b0, abs_i} + {1'b0, abs_q};
    rext_i = (ACC_W+1)'(ref_i_o);
    rext_q = (ACC_W+1)'(ref_q_o);
    rabs_i = rext_i[ACC_W] ? -rext_i : rext_i;
    rabs_q = rext_q[ACC_W] ? -rext_q : rext_q;
  end

  assign amp_ok_o  = amp > AMP_W'(THRESH);
  assign i_dom     = rabs_i > rabs_q;
  assign s_neg_i   = smp_i_i[SMP_W-1];
  assign s_pos_i   = !smp_i_i[SMP_W-1] && |smp_i_i;
  assign s_neg_q   = smp_q_i[SMP_W-1];
  assign s_pos_q   = !smp_q_i[SMP_W-1] && |smp_q_i;
  assign r_neg_i   = ref_i_o[ACC_W-1];
  assign r_pos_i   = !ref_i_o[ACC_W-1] && |ref_i_o;
  assign r_neg_q   = ref_q_o[ACC_W-1];
  assign r_pos_q   = !ref_q_o[ACC_W-1] && |ref_q_o;
  assign match_o   = i_dom ? ((s_pos_i && r_pos_i) || (s_neg_i && r_neg_i))
                           : ((s_pos_q && r_pos_q) || (s_neg_q && r_neg_q));
  assign trained_o = cnt_q >= CNT_W'(TRAIN_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_i_o <= '0;
      ref_q_o <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      ref_i_o <= ACC_W'(smp_i_i);
      ref_q_o <= ACC_W'(smp_q_i);
      cnt_q   <= CNT_W'(1);
    end else if (upd_i && !trained_o) begin
      ref_i_o <= ref_i_o + ACC_W'(smp_i_i);
      ref_q_o <= ref_q_o + ACC_W'(smp_q_i);
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  AST_REF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trained_o && !load_i) |=> ($stable(ref_i_o) && $stable(ref_q_o))); // R4
endmodule

// File: rtl/bpsk_dot.sv
module bpsk_dot #(
  parameter int SMP_W = 8,
  parameter int ACC_W = 13,
  parameter int DOT_W = 23
) (
  input  logic signed [SMP_W-1:0] smp_i_i,
  input  logic signed [SMP_W-1:0] smp_q_i,
  input  logic signed [ACC_W-1:0] ref_i_i,
  input  logic signed [ACC_W-1:0] ref_q_i,
  output logic signed [DOT_W-1:0] dot_o,
  output logic                    pos_o,
  output logic                    neg_o
);
  logic signed [DOT_W-1:0] p_i, p_q;

  always_comb begin
    p_i   = DOT_W'(smp_i_i) * DOT_W'(ref_i_i);
    p_q   = DOT_W'(smp_q_i) * DOT_W'(ref_q_i);
    dot_o = p_i + p_q;
  end

  assign neg_o = dot_o[DOT_W-1];
  assign pos_o = !dot_o[DOT_W-1] && |dot_o;
endmodule

// File: rtl/bpsk_char_asm.sv
module bpsk_char_asm
  import bpsk_rx_pkg::*;
#(
  parameter int DOT_W  = 23,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    run_i,
  input  logic signed [DOT_W-1:0] dot_i,
  output logic                    done_o,
  output char_kind_e              kind_o,
  output logic [DATA_W-1:0]       data_o
);
  localparam int CHAR_W = DATA_W + 2;
  localparam int BC_W   = $clog2(CHAR_W);

  logic                    half_q;
  logic signed [DOT_W-1:0] first_q, bit_sum;
  logic [BC_W-1:0]         cnt_q;
  logic [CHAR_W-1:0]       sh_q, char_nx;
  logic                    bit_v;

  always_comb begin
    bit_sum = first_q + dot_i;
    bit_v   = !bit_sum[DOT_W-1] && |bit_sum;
    char_nx = {bit_v, sh_q[CHAR_W-1:1]};
  end

  assign done_o = run_i && half_q && (cnt_q == BC_W'(CHAR_W - 1));
  assign data_o = char_nx[CHAR_W-2:1];

  always_comb begin
    if (char_nx == '0)                             kind_o = CH_SOF_EOF;
    else if (!char_nx[0] && char_nx[CHAR_W-1])     kind_o = CH_BYTE;
    else                                           kind_o = CH_BAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      first_q <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (start_i) begin
      half_q  <= 1'b1;
      first_q <= dot_i;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (run_i) begin
      if (!half_q) begin
        half_q  <= 1'b1;
        first_q <= dot_i;
      end else begin
        half_q <= 1'b0;
        sh_q   <= char_nx;
        cnt_q  <= done_o ? '0 : cnt_q + BC_W'(1);
      end
    end
  end

  AST_BITCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < BC_W'(CHAR_W)); // R6
endmodule

// File: rtl/bpsk_frame_rx.sv
module bpsk_frame_rx
  import bpsk_rx_pkg::*;
#(
  parameter int SMP_W      = 8,
  parameter int DATA_W     = 8,
  parameter int TRAIN_LEN  = 10,
  parameter int THRESH     = 24,
  parameter int SOF_PRESET = 20,
  parameter int SOF_MIN    = 18,
  parameter int SOF_MAX    = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_valid_i,
  input  logic signed [SMP_W-1:0] smp_i_i,
  input  logic signed [SMP_W-1:0] smp_q_i,
  output logic                    byte_valid_o,
  output logic [DATA_W-1:0]       byte_o,
  output logic                    eof_o,
  output logic                    sync_lost_o,
  output logic                    active_o
);
  localparam int ACC_W = SMP_W + $clog2(TRAIN_LEN) + 1;
  localparam int DOT_W = SMP_W + ACC_W + 2;
  localparam int SOF_W = $clog2(SOF_MAX + 2);

  rx_state_e               state_q, state_d;
  logic [SOF_W-1:0]        sof_q, sof_d, sof_inc;
  logic                    got_q, got_d;
  logic                    bv_d, eof_d, lost_d;
  logic [DATA_W-1:0]       byte_d;
  logic                    ref_load, ref_upd, asm_start, asm_run;
  logic signed [ACC_W-1:0] ref_i, ref_q;
  logic                    amp_ok, match, trained;
  logic signed [DOT_W-1:0] dot;
  logic                    dot_pos, dot_neg;
  logic                    ch_done;
  char_kind_e              ch_kind;
  logic [DATA_W-1:0]       ch_data;

  bpsk_ref_acc #(
    .SMP_W(SMP_W), .ACC_W(ACC_W), .TRAIN_LEN(TRAIN_LEN), .THRESH(THRESH)
  ) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ref_load), .upd_i(ref_upd),
    .smp_i_i(smp_i_i), .smp_q_i(smp_q_i), .ref_i_o(ref_i), .ref_q_o(ref_q),
    .amp_ok_o(amp_ok), .match_o(match), .trained_o(trained)
  );

  bpsk_dot #(.SMP_W(SMP_W), .ACC_W(ACC_W), .DOT_W(DOT_W)) u_dot (
    .smp_i_i(smp_i_i), .smp_q_i(smp_q_i), .ref_i_i(ref_i), .ref_q_i(ref_q),
    .dot_o(dot), .pos_o(dot_pos), .neg_o(dot_neg)
  );

  bpsk_char_asm #(.DOT_W(DOT_W), .DATA_W(DATA_W)) u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(asm_start), .run_i(asm_run),
    .dot_i(dot), .done_o(ch_done), .kind_o(ch_kind), .data_o(ch_data)
  );

  assign sof_inc = sof_q + SOF_W'(1);

  always_comb begin
    state_d   = state_q;
    sof_d     = sof_q;
    got_d     = got_q;
    byte_d    = byte_o;
    bv_d      = 1'b0;
    eof_d     = 1'b0;
    lost_d    = 1'b0;
    ref_load  = 1'b0;
    ref_upd   = 1'b0;
    asm_start = 1'b0;
    asm_run   = 1'b0;
    if (smp_valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (amp_ok) begin
            ref_load = 1'b1;
            state_d  = ST_TRAIN;
          end
        end
        ST_TRAIN: begin
          if (!amp_ok) begin
            lost_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (match) begin
            ref_upd = 1'b1;
          end else if (!trained) begin
            lost_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            // flip sample is first half of the first bit (SOF low or start bit)
            asm_start = 1'b1;
            got_d     = 1'b0;
            state_d   = ST_DATA;
          end
        end
        ST_DATA: begin
          asm_run = 1'b1;
          if (ch_done) begin
            unique case (ch_kind)
              CH_SOF_EOF: begin
                if (got_q) begin
                  eof_d   = 1'b1;
                  state_d = ST_IDLE;
                end else begin
                  sof_d   = SOF_W'(SOF_PRESET);
                  state_d = ST_SOF_RISE;
                end
              end
              CH_BYTE: begin
                bv_d    = 1'b1;
                byte_d  = ch_data;
                got_d   = 1'b1;
                state_d = ST_WAIT_START;
              end
              default: begin
                lost_d  = 1'b1;
                state_d = ST_IDLE;
              end
            endcase
          end
        end
        ST_WAIT_START: begin
          if (dot_neg) begin
            asm_start = 1'b1;
            state_d   = ST_DATA;
          end
        end
        ST_SOF_RISE: begin
          sof_d = sof_inc;
          if (dot_pos) begin
            if (sof_inc < SOF_W'(SOF_MIN)) begin
              lost_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              got_d   = 1'b0;
              state_d = ST_WAIT_START;
            end
          end else if (sof_inc > SOF_W'(SOF_MAX)) begin
            lost_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sof_q        <= '0;
      got_q        <= 1'b0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      eof_o        <= 1'b0;
      sync_lost_o  <= 1'b0;
    end else begin
      state_q      <= state_d;
      sof_q        <= sof_d;
      got_q        <= got_d;
      byte_o       <= byte_d;
      byte_valid_o <= bv_d;
      eof_o        <= eof_d;
      sync_lost_o  <= lost_d;
    end
  end

  assign active_o = (state_q == ST_WAIT_START) || (state_q == ST_DATA);

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, eof_o, sync_lost_o})); // R12
  AST_EVENT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o || eof_o || sync_lost_o) |=> !(byte_valid_o || eof_o || sync_lost_o)); // R12
  AST_EOF_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> $past(got_q)); // R7
  AST_BYTE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> active_o); // R6
  AST_LOST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lost_o |-> !active_o); // R2
  AST_SOF_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOF_RISE) |-> (sof_q <= SOF_W'(SOF_MAX))); // R8
  AST_HOLD_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(state_q) && !byte_valid_o && !eof_o && !sync_lost_o)); // R11
endmodule

// File: tb/tb_bpsk_frame_rx.sv
`timescale 1ns/1ps
module tb_bpsk_frame_rx;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              smp_valid_i = 1'b0;
  logic signed [7:0] smp_i_i = '0;
  logic signed [7:0] smp_q_i = '0;
  logic              byte_valid_o, eof_o, sync_lost_o, active_o;
  logic [7:0]        byte_o;

  bpsk_frame_rx dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
    .smp_i_i(smp_i_i), .smp_q_i(smp_q_i), .byte_valid_o(byte_valid_o),
    .byte_o(byte_o), .eof_o(eof_o), .sync_lost_o(sync_lost_o), .active_o(active_o)
  );

  always #2.5 clk_i = ~clk_i;

  localparam int EV_NONE = 0, EV_BYTE = 1, EV_EOF = 2, EV_LOST = 3;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  int    oi = 60, oq = 20, zi = -60, zq = -20;
  logic [7:0] exp_byte = 8'h00;

  // reference model: every driven sample carries the events it must cause
  task automatic step(input bit v, input int si, input int sq, input int ev, input bit act);
    smp_valid_i = v;
    smp_i_i     = si[7:0];
    smp_q_i     = sq[7:0];
    @(negedge clk_i);
    n_chk++;
    if (byte_valid_o !== (ev == EV_BYTE) || eof_o !== (ev == EV_EOF) ||
        sync_lost_o !== (ev == EV_LOST) || active_o !== act ||
        (ev == EV_BYTE && byte_o !== exp_byte)) begin
      n_fail++;
      $display("FAIL %s: bv=%0b byte=%h eof=%0b lost=%0b act=%0b expected ev=%0d byte=%h act=%0b",
               cur_req, byte_valid_o, byte_o, eof_o, sync_lost_o, active_o, ev, exp_byte, act);
    end
  endtask

  task automatic ph(input bit b, input int ev, input bit act);
    step(1'b1, b ? oi : zi, b ? oq : zq, ev, act);
  endtask

  task automatic train(input int n);
    for (int k = 0; k < n; k++) ph(1'b1, EV_NONE, 1'b0);
  endtask

  task automatic silence(input int n);
    for (int k = 0; k < n; k++) step(1'b1, 0, 0, EV_NONE, 1'b0);
  endtask

  task automatic stuff(input int n);
    for (int k = 0; k < 2 * n; k++) ph(1'b1, EV_NONE, 1'b1);
  endtask

  // bits[0] sent first; noisy weakens first halves of data bits; gap inserts invalid cycles
  task automatic rawchr(input logic [9:0] bits, input int ev, input bit act_last,
                        input bit noisy, input bit gap);
    for (int k = 0; k < 10; k++) begin
      bit b = bits[k];
      if (noisy && k >= 1 && k <= 8)
        step(1'b1, (b ? zi : oi) / 6, (b ? zq : oq) / 6, EV_NONE, 1'b1);
      else
        ph(b, EV_NONE, 1'b1);
      if (gap && k == 3)
        for (int g = 0; g < 3; g++) step(1'b0, -100, -100, EV_NONE, 1'b1);
      if (k == 9) ph(b, ev, act_last);
      else        ph(b, EV_NONE, 1'b1);
    end
  endtask

  task automatic chr(input logic [7:0] d, input bit noisy, input bit gap);
    exp_byte = d;
    rawchr({1'b1, d, 1'b0}, EV_BYTE, 1'b1, noisy, gap);
  endtask

  task automatic eof_chr();
    rawchr(10'h000, EV_EOF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic sof_frame(input int extra_low);
    train(15);
    rawchr(10'h000, EV_NONE, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < extra_low; k++) ph(1'b0, EV_NONE, 1'b0);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected end of stimulus");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    n_chk++;
    if (byte_valid_o !== 1'b0 || eof_o !== 1'b0 || sync_lost_o !== 1'b0 ||
        active_o !== 1'b0 || byte_o !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: bv=%0b eof=%0b lost=%0b act=%0b byte=%h expected all 0",
               byte_valid_o, eof_o, sync_lost_o, active_o, byte_o);
    end
    rst_ni = 1'b1;
    silence(3);

    // R2: threshold boundary in idle and during training
    cur_req = "R2";
    step(1'b1, 12, 12, EV_NONE, 1'b0);
    silence(2);
    train(4);
    step(1'b1, 12, 12, EV_LOST, 1'b0);
    silence(2);
    train(6);
    step(1'b1, 0, 0, EV_LOST, 1'b0);
    silence(2);

    // R4: training length boundary
    cur_req = "R4";
    train(9);
    ph(1'b0, EV_LOST, 1'b0);
    silence(2);
    train(10);
    chr(8'h55, 1'b0, 1'b0);
    cur_req = "R7";
    eof_chr();
    silence(2);

    // R6: reduced framing, two bytes with stuff bits between
    cur_req = "R6";
    train(12);
    chr(8'hA5, 1'b0, 1'b0);
    stuff(3);
    chr(8'h01, 1'b0, 1'b0);
    chr(8'h80, 1'b0, 1'b0);
    // R5: weak opposite first halves
    cur_req = "R5";
    chr(8'h3C, 1'b1, 1'b0);
    stuff(1);
    // R11: invalid cycles inside a character
    cur_req = "R11";
    chr(8'hC6, 1'b0, 1'b1);
    step(1'b0, -100, -100, EV_NONE, 1'b1);
    cur_req = "R7";
    eof_chr();
    silence(2);

    // R8: full framing, rising edge right after the SOF character
    cur_req = "R8";
    sof_frame(0);
    ph(1'b1, EV_NONE, 1'b1);
    stuff(2);
    cur_req = "R10";
    chr(8'h81, 1'b0, 1'b0);
    chr(8'h7E, 1'b0, 1'b0);
    eof_chr();
    silence(2);

    // R8: longest tolerated low phase, then one too long
    cur_req = "R8";
    sof_frame(4);
    ph(1'b1, EV_NONE, 1'b1);
    stuff(1);
    chr(8'h42, 1'b0, 1'b0);
    eof_chr();
    silence(2);
    sof_frame(4);
    ph(1'b0, EV_LOST, 1'b0);
    silence(2);

    // R9: stop bit 0 with non-zero content
    cur_req = "R9";
    train(12);
    chr(8'h11, 1'b0, 1'b0);
    rawchr({1'b0, 8'h5A, 1'b0}, EV_LOST, 1'b0, 1'b0, 1'b0);
    silence(2);

    // R3: Q-dominant reference; zero phase agrees on I, flips on Q
    cur_req = "R3";
    oi = 10; oq = -70; zi = 10; zq = 70;
    train(9);
    ph(1'b0, EV_LOST, 1'b0);
    silence(2);
    train(12);
    chr(8'hC3, 1'b0, 1'b0);
    stuff(2);
    chr(8'h0F, 1'b0, 1'b0);
    eof_chr();
    silence(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule